// File: doc/BRIEF.md
# UART Register and Interrupt Front End

This block sits between a processor bus and the bit-level engine of a simple serial port. It decodes a small window of byte-wide registers, each on its own 32-bit word, and gives software four identification bytes, a data port, one combined control/status register and a 16-bit baud divisor split over two bytes. Received bytes queue in a small receive FIFO. A transmit byte waits in a single holding register until the serial engine takes it.

The serial engine delivers each received byte with a one-cycle push that also carries a frame-error flag. It takes transmit bytes through a valid/accept handshake. It reads the baud divisor from a dedicated output. One interrupt line covers both directions. It is raised by pending receive data or by free room in the transmit register, each gated by its own enable bit. Software keeps reading the data port until the status register shows the FIFO empty. It writes the data port only while the status register shows the transmit register empty.

Top module: `uart_regif`

## Requirements
- R1: After reset the STATUS register reads 0xA0 (receive FIFO empty, transmit register empty, both enables and both error bits clear), irq is low, baud_div equals BAUD_RESET, and a read of DATA returns 0x00.
- R2: bus_addr[4:2] selects the register: 0 to 3 ID bytes, 4 DATA, 5 STATUS, 6 BAUDL, 7 BAUDH. bus_addr[1:0] are ignored.
- R3: ID register k returns ID_WORD[8k+7:8k], and writes to the ID registers have no effect.
- R4: STATUS bit layout: bit0 frame error, bit1 overrun, bit2 receive interrupt enable, bit3 FIFO full, bit4 FIFO holds exactly RX_DEPTH-1 bytes, bit5 FIFO empty, bit6 transmit interrupt enable, bit7 transmit register empty.
- R5: The receive FIFO holds RX_DEPTH (default 4) bytes in arrival order. Each read of DATA while it is not empty returns the oldest byte and removes it.
- R6: A read of DATA while the FIFO is empty returns the byte most recently removed and leaves the FIFO unchanged.
- R7: A push that arrives while the FIFO is full sets the overrun bit, and the byte is dropped without changing the FIFO contents.
- R8: A push with rx_ferr high sets the frame error bit. The byte is still stored if there is room.
- R9: The error bits are sticky. A STATUS write clears each error bit whose written value is 0 and never sets one. An error event in the same cycle as a clearing write leaves the bit set.
- R10: STATUS bits 2 and 6 are read/write enables. Writes to bits 3, 4, 5 and 7 have no effect.
- R11: A DATA write while the transmit register is empty loads it: tx_valid rises on the next cycle with the byte and bit7 clears. A DATA write while it is full is ignored. tx_accept while tx_valid is high empties the register on the next cycle.
- R12: irq is high exactly when (receive enable and FIFO not empty) or (transmit enable and transmit register empty).
- R13: BAUDL and BAUDH read back their written values and drive baud_div = {BAUDH, BAUDL}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address within the register window |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access; DATA reads pop the FIFO |
| bus_rdata | output | 8 | Read data, combinational from the current state |
| irq | output | 1 | Combined receive/transmit interrupt |
| tx_byte | output | 8 | Byte offered to the serial engine |
| tx_valid | output | 1 | Transmit register holds a byte |
| tx_accept | input | 1 | Serial engine takes the byte |
| rx_byte | input | 8 | Received byte |
| rx_push | input | 1 | Received byte is valid this cycle |
| rx_ferr | input | 1 | Stop bit was missing for this byte |
| baud_div | output | 16 | Baud divisor to the serial engine |

## Verification
The bench fills the FIFO to the full and one-left levels and pushes past the limit. A design that stored the extra byte or lost an old one would return the wrong sequence, and one that missed the overrun would show a clean status. It reads the empty FIFO, where a design that moved its pointers would later return stale or duplicated bytes instead of the last byte read. It clears an error bit in the same cycle as a new frame error. A design that gave the write priority would lose the error. It also writes ones to the read-only flags and offers a second transmit byte while the first is pending, which catches a design that latches those writes.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;
   localparam int unsigned REG_W = 8;

   typedef enum logic [2:0] {
      SEL_ID0   = 3'd0,
      SEL_ID1   = 3'd1,
      SEL_ID2   = 3'd2,
      SEL_ID3   = 3'd3,
      SEL_DATA  = 3'd4,
      SEL_STAT  = 3'd5,
      SEL_BAUDL = 3'd6,
      SEL_BAUDH = 3'd7
   } reg_sel_e;

   // status bit positions, decoded by software
   localparam int unsigned ST_FERR    = 0;
   localparam int unsigned ST_OVR     = 1;
   localparam int unsigned ST_RXIE    = 2;
   localparam int unsigned ST_RXFULL  = 3;
   localparam int unsigned ST_RXONE   = 4;
   localparam int unsigned ST_RXEMPTY = 5;
   localparam int unsigned ST_TXIE    = 6;
   localparam int unsigned ST_TXEMPTY = 7;
endpackage

// File: rtl/uart_rx_queue.sv
module uart_rx_queue #(
   parameter int unsigned DEPTH  = 4,
   parameter int unsigned DATA_W = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         push,
   input  logic [DATA_W-1:0]            push_data,
   input  logic                         pop,
   output logic [DATA_W-1:0]            head,
   output logic [$clog2(DEPTH+1)-1:0]   cnt,
   output logic                         full,
   output logic                         one_left,
   output logic                         empty
);
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);
   localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

   generate
      if (DEPTH < 2) begin : g_depth_bad
         $error("uart_rx_queue: DEPTH must be at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] slots [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic              do_push, do_pop;

   assign full     = (cnt == CNT_W'(DEPTH));
   assign one_left = (cnt == CNT_W'(DEPTH - 1));
   assign empty    = (cnt == '0);
   assign do_push  = push & ~full;
   assign do_pop   = pop & ~empty;
   assign head     = slots[rd_ptr];

   function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
      return (p == LAST_PTR) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
         for (int i = 0; i < int'(DEPTH); i++) slots[i] <= '0;
      end else begin
         if (do_push) begin
            slots[wr_ptr] <= push_data;
            wr_ptr        <= bump(wr_ptr);
         end
         if (do_pop) rd_ptr <= bump(rd_ptr);
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  logic              accept,
   output logic              valid,
   output logic [DATA_W-1:0] data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
         data  <= '0;
      end else if (valid) begin
         if (accept) valid <= 1'b0;
      end else if (load) begin
         valid <= 1'b1;
         data  <= load_data;
      end
   end
endmodule

// File: rtl/uart_regif.sv
module uart_regif
   import uart_regif_pkg::*;
#(
   parameter int unsigned ADDR_W     = 5,
   parameter int unsigned RX_DEPTH   = 4,
   parameter logic [31:0] ID_WORD    = 32'h0153_4D41,
   parameter logic [15:0] BAUD_RESET = 16'h0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   input  logic              bus_wr,
   input  logic              bus_rd,
   output logic [7:0]        bus_rdata,
   output logic              irq,
   output logic [7:0]        tx_byte,
   output logic              tx_valid,
   input  logic              tx_accept,
   input  logic [7:0]        rx_byte,
   input  logic              rx_push,
   input  logic              rx_ferr,
   output logic [15:0]       baud_div
);
   localparam int unsigned CNT_W  = $clog2(RX_DEPTH + 1);
   localparam int unsigned N_ID   = 4;

   generate
      if (ADDR_W < 5) begin : g_addr_bad
         $error("uart_regif: ADDR_W must cover eight word registers");
      end
   endgenerate

   reg_sel_e            sel;
   logic [REG_W-1:0]    id_byte [N_ID];
   logic [REG_W-1:0]    rxq_head, last_rd, baud_lo, baud_hi, status;
   logic [CNT_W-1:0]    rx_cnt;
   logic                rxq_full, rxq_one, rxq_empty;
   logic                rxie, txie, ovr, ferr;
   logic                rd_data, wr_data, wr_stat, ovr_evt, ferr_evt;

   genvar k;
   generate
      for (k = 0; k < N_ID; k++) begin : g_id
         assign id_byte[k] = ID_WORD[8*k +: 8];
      end
   endgenerate

   assign sel      = reg_sel_e'(bus_addr[4:2]);
   assign rd_data  = bus_rd & (sel == SEL_DATA);
   assign wr_data  = bus_wr & (sel == SEL_DATA);
   assign wr_stat  = bus_wr & (sel == SEL_STAT);
   assign ovr_evt  = rx_push & rxq_full;
   assign ferr_evt = rx_push & rx_ferr;

   uart_rx_queue #(.DEPTH(RX_DEPTH), .DATA_W(REG_W)) u_rxq (
      .clk(clk), .rst_n(rst_n),
      .push(rx_push), .push_data(rx_byte), .pop(rd_data),
      .head(rxq_head), .cnt(rx_cnt),
      .full(rxq_full), .one_left(rxq_one), .empty(rxq_empty)
   );

   uart_tx_hold #(.DATA_W(REG_W)) u_txh (
      .clk(clk), .rst_n(rst_n),
      .load(wr_data), .load_data(bus_wdata), .accept(tx_accept),
      .valid(tx_valid), .data(tx_byte)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rxie    <= 1'b0;
         txie    <= 1'b0;
         ovr     <= 1'b0;
         ferr    <= 1'b0;
         last_rd <= '0;
         baud_lo <= BAUD_RESET[7:0];
         baud_hi <= BAUD_RESET[15:8];
      end else begin
         if (wr_stat) begin
            rxie <= bus_wdata[ST_RXIE];
            txie <= bus_wdata[ST_TXIE];
            ovr  <= (ovr  & bus_wdata[ST_OVR])  | ovr_evt;
            ferr <= (ferr & bus_wdata[ST_FERR]) | ferr_evt;
         end else begin
            ovr  <= ovr  | ovr_evt;
            ferr <= ferr | ferr_evt;
         end
         if (rd_data && !rxq_empty) last_rd <= rxq_head;
         if (bus_wr && sel == SEL_BAUDL) baud_lo <= bus_wdata;
         if (bus_wr && sel == SEL_BAUDH) baud_hi <= bus_wdata;
      end
   end

   always_comb begin
      status              = '0;
      status[ST_FERR]     = ferr;
      status[ST_OVR]      = ovr;
      status[ST_RXIE]     = rxie;
      status[ST_RXFULL]   = rxq_full;
      status[ST_RXONE]    = rxq_one;
      status[ST_RXEMPTY]  = rxq_empty;
      status[ST_TXIE]     = txie;
      status[ST_TXEMPTY]  = ~tx_valid;
   end

   always_comb begin
      case (sel)
         SEL_DATA:  bus_rdata = rxq_empty ? last_rd : rxq_head;
         SEL_STAT:  bus_rdata = status;
         SEL_BAUDL: bus_rdata = baud_lo;
         SEL_BAUDH: bus_rdata = baud_hi;
         default:   bus_rdata = id_byte[sel[1:0]];
      endcase
   end

   assign irq      = (rxie & ~rxq_empty) | (txie & ~tx_valid);
   assign baud_div = {baud_hi, baud_lo};
endmodule

// File: rtl/uart_regif_chk.sv
module uart_regif_chk #(
   parameter int unsigned ADDR_W   = 5,
   parameter int unsigned RX_DEPTH = 4,
   parameter int unsigned CNT_W    = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_rd,
   input logic              bus_wr,
   input logic              rx_push,
   input logic              tx_accept,
   input logic              tx_valid,
   input logic [7:0]        tx_byte,
   input logic              irq,
   input logic [CNT_W-1:0]  rx_cnt,
   input logic              rxie,
   input logic              txie,
   input logic              ovr,
   input logic              ferr
);
   logic data_rd, stat_wr;
   assign data_rd = bus_rd && (bus_addr[4:2] == 3'd4);
   assign stat_wr = bus_wr && (bus_addr[4:2] == 3'd5);

   // R12
   irq_equation_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq == ((rxie && rx_cnt != '0) || (txie && !tx_valid)));

   // R5
   fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_cnt <= CNT_W'(RX_DEPTH));

   // R7
   overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_push && rx_cnt == CNT_W'(RX_DEPTH)) |=> ovr);

   // R7
   overrun_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_push && rx_cnt == CNT_W'(RX_DEPTH) && !data_rd) |=> rx_cnt == CNT_W'(RX_DEPTH));

   // R6
   empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd && rx_cnt == '0 && !rx_push) |=> rx_cnt == '0);

   // R9
   error_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((ovr || ferr) && !stat_wr) |=> (ovr || !$past(ovr)) && (ferr || !$past(ferr)));

   // R11
   tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_accept) |=> tx_valid && $stable(tx_byte));
endmodule

bind uart_regif uart_regif_chk #(
   .ADDR_W(ADDR_W), .RX_DEPTH(RX_DEPTH), .CNT_W($clog2(RX_DEPTH + 1))
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
   .bus_wr(bus_wr), .rx_push(rx_push), .tx_accept(tx_accept),
   .tx_valid(tx_valid), .tx_byte(tx_byte), .irq(irq), .rx_cnt(rx_cnt),
   .rxie(rxie), .txie(txie), .ovr(ovr), .ferr(ferr)
);

// File: tb/test_uart_regif.sv
module test_uart_regif;
   localparam int DEPTH = 4;
   localparam logic [31:0] IDW = 32'h0153_4D41;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0] bus_rdata, tx_byte, rx_byte = '0;
   logic       irq, tx_valid, tx_accept = 1'b0, rx_push = 1'b0, rx_ferr = 1'b0;
   logic [15:0] baud_div;

   int checks = 0, failures = 0;
   bit done = 0;

   // bench model
   logic [7:0] q[$];
   logic [7:0] m_last = 8'h00, m_tx = 8'h00;
   bit m_ovr, m_fer, m_rxie, m_txie, m_txfull;

   always #2 clk = ~clk;

   uart_regif #(.RX_DEPTH(DEPTH), .ID_WORD(IDW)) i_uart_regif (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq),
      .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_accept(tx_accept),
      .rx_byte(rx_byte), .rx_push(rx_push), .rx_ferr(rx_ferr), .baud_div(baud_div)
   );

   function automatic logic [7:0] exp_status();
      return {~m_txfull, m_txie, q.size() == 0, q.size() == DEPTH - 1,
              q.size() == DEPTH, m_rxie, m_ovr, m_fer};
   endfunction

   function automatic logic exp_irq();
      return (m_rxie && q.size() != 0) || (m_txie && !m_txfull);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [4:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic wr(input logic [4:0] a, input logic [7:0] v);
      @(negedge clk);
      bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      case (a[4:2])
         3'd4: if (!m_txfull) begin m_txfull = 1; m_tx = v; end
         3'd5: begin m_rxie = v[2]; m_txie = v[6]; m_ovr &= v[1]; m_fer &= v[0]; end
         default: ;
      endcase
   endtask

   task automatic push(input logic [7:0] b, input bit fe);
      @(negedge clk);
      rx_byte = b; rx_push = 1'b1; rx_ferr = fe;
      @(negedge clk);
      rx_push = 1'b0; rx_ferr = 1'b0;
      if (fe) m_fer = 1;
      if (q.size() == DEPTH) m_ovr = 1; else q.push_back(b);
   endtask

   task automatic chk_status(input string req);
      logic [7:0] d;
      rd(5'd20, d);
      chk(d == exp_status(), req, d, exp_status());
   endtask

   task automatic chk_data(input string req);
      logic [7:0] d, e;
      e = (q.size() != 0) ? q[0] : m_last;
      rd(5'd16, d);
      chk(d == e, req, d, e);
      if (q.size() != 0) m_last = q.pop_front();
   endtask

   task automatic take_tx(input string req);
      @(negedge clk);
      chk(tx_valid == m_txfull, req, tx_valid, m_txfull);
      if (m_txfull) chk(tx_byte == m_tx, req, tx_byte, m_tx);
      tx_accept = tx_valid;
      @(negedge clk);
      tx_accept = 1'b0;
      m_txfull = 0;
   endtask

   task automatic chk_irq(input string req);
      @(negedge clk);
      chk(irq == exp_irq(), req, irq, exp_irq());
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=0x0 expected=0x1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      void'($urandom(32'd2741));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk_status("R1 status after reset");
      chk(irq == 1'b0, "R1 irq after reset", irq, 0);
      chk(baud_div == 16'h0000, "R1 baud after reset", baud_div, 0);
      chk_data("R1 data before any byte");

      // R2 / R3 identification bytes, low address bits ignored, writes ignored
      for (int k = 0; k < 4; k++) begin
         rd(5'(4 * k + (k % 4)), d);
         chk(d == IDW[8*k +: 8], "R2 R3 id read", d, IDW[8*k +: 8]);
         wr(5'(4 * k), 8'hEE);
         rd(5'(4 * k), d);
         chk(d == IDW[8*k +: 8], "R3 id write ignored", d, IDW[8*k +: 8]);
      end

      // R13 baud divisor
      wr(5'd24, 8'h34);
      wr(5'd31, 8'h12);
      chk(baud_div == 16'h1234, "R13 baud_div", baud_div, 16'h1234);
      rd(5'd24, d); chk(d == 8'h34, "R13 baudl readback", d, 8'h34);
      rd(5'd28, d); chk(d == 8'h12, "R13 baudh readback", d, 8'h12);

      // R4 R5 R7 fill, one-left, full, overrun
      push(8'hA1, 0); push(8'hB2, 0); push(8'hC3, 0);
      chk_status("R4 one slot left");
      push(8'hD4, 0);
      chk_status("R4 fifo full");
      push(8'hE5, 0);
      chk_status("R7 overrun set");
      for (int i = 0; i < DEPTH; i++) chk_data("R5 fifo order");
      // R6 empty reads
      chk_data("R6 empty read returns last");
      chk_data("R6 second empty read");
      chk_status("R6 still empty");

      // R8 R9 frame error and sticky clear
      push(8'h3C, 1);
      chk_status("R8 frame error set");
      chk_data("R8 byte stored");
      wr(5'd20, 8'h03);
      chk_status("R9 write of ones keeps errors");
      wr(5'd20, 8'h00);
      chk_status("R9 write of zeros clears");
      // R9 event wins over clearing write in the same cycle
      @(negedge clk);
      bus_addr = 5'd20; bus_wdata = 8'h00; bus_wr = 1'b1;
      rx_byte = 8'h5D; rx_push = 1'b1; rx_ferr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; rx_push = 1'b0; rx_ferr = 1'b0;
      m_rxie = 0; m_txie = 0; m_fer = 1; q.push_back(8'h5D);
      chk_status("R9 same-cycle error survives");
      chk_data("R9 byte stored");
      wr(5'd20, 8'h00);

      // R10 read-only flags ignore writes, enables stick
      wr(5'd20, 8'hB8);
      chk_status("R10 flags unaffected by write");
      wr(5'd20, 8'h44);
      chk_status("R10 enables read back");
      chk_irq("R12 tx room irq");
      wr(5'd20, 8'h04);
      chk_irq("R12 no irq enable rx only empty");
      push(8'h11, 0);
      chk_irq("R12 rx data irq");
      chk_data("R5 drain");
      wr(5'd20, 8'h00);

      // R11 transmit holding register
      wr(5'd16, 8'h5A);
      chk_status("R11 tx full status");
      wr(5'd16, 8'h77);
      take_tx("R11 second write ignored");
      chk_status("R11 tx empty after accept");

      // random mix
      for (int n = 0; n < 800; n++) begin
         int op;
         op = int'($urandom_range(0, 6));
         case (op)
            0, 1: push(8'($urandom), ($urandom_range(0, 7) == 0));
            2:    chk_data("R5 R6 random data read");
            3:    chk_status("R4 random status");
            4:    wr(5'd20, 8'($urandom));
            5:    wr(5'd16, 8'($urandom));
            default: take_tx("R11 random accept");
         endcase
         chk_irq("R12 random irq");
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule